// File: doc/BRIEF.md
# Bridge Command Decoder and Register File

This block is the host-facing command interpreter of a bridge between a byte-oriented host bus and a 1-Wire bus master. The host delivers a command byte and, for some commands, one parameter byte through a write strobe. A flag marks which byte opens a command. A read of the block returns one of four registers: status, data, channel or configuration. An internal read pointer chooses the register, and each accepted command moves that pointer on its own.

The block checks configuration writes with a complement code and accepts channel selections only through fixed, non-binary codes. It holds the resulting configuration and channel. Line operations go to a separate 1-Wire timing engine as a one-cycle start pulse with an operation code and an argument byte. When the engine signals completion, the block captures the engine's result flags and its received byte. While an operation is running, the block refuses any further line command.

Top module: `owb_cmd_bridge`

## Requirements
- R1: Out of hardware reset, and after the device-reset command 0xF0, status reads exactly 0x18 (reset flag bit 4 plus line level bit 3 with `lineLevel` high), configuration and channel are zero, the busy bit (status bit 0) is clear, and the pointer selects status.
- R2: Command 0xE1 with parameter 0xF0 / 0xE1 / 0xD2 / 0xC3 points reads at status / data / channel / configuration; any other parameter leaves the pointer unchanged.
- R3: An accepted line command or device reset moves the pointer to status, an accepted configuration write moves it to configuration, and an accepted channel select moves it to channel.
- R4: The configuration register reads as zero in bits 7:4 and as the stored value in bits 3:0 (bit 3 speed, bit 2 strong pull-up, bit 1 presence masking, bit 0 active pull-up), which also drives `cfgOut`.
- R5: Command 0xD2 stores its parameter's low nibble only when the high nibble is the ones' complement of the low nibble; otherwise configuration and pointer stay unchanged.
- R6: Command 0xC3 selects channel n when its parameter is 0xF0 - 15*n (n below NUM_CHAN), after which the channel register reads 0xB8 - 7*n; any other parameter leaves channel and pointer unchanged.
- R7: The reset flag (status bit 4) clears on the first accepted configuration write after a reset.
- R8: A line command (0xB4 bus reset, 0x96 read byte, 0x87 single bit, 0xA5 write byte, 0x78 triplet) drives `engStart` high for exactly the cycle after its last byte is taken, with `engOp` 1 / 4 / 2 / 3 / 5 respectively, and sets the busy bit.
- R9: A line command received while the busy bit is set is dropped: no start pulse and no change to any register or to the pointer.
- R10: `engDone` while busy clears the busy bit and copies `engFlags` {bit7, bit6, bit5, bit2, bit1} into status. The data register loads `engData` only when the finished operation was a read byte.
- R11: `engArg` carries the parameter for write byte and 0xFF or 0x00 for single bit and triplet, following parameter bit 7. It is 0x00 for bus reset and read byte.
- R12: A parameter byte with no pending command, and an unknown command byte, change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hostWr | input | 1 | Host byte strobe |
| hostFirst | input | 1 | Byte is a command byte (otherwise a parameter) |
| hostData | input | 8 | Host byte |
| rdData | output | 8 | Register selected by the read pointer |
| engStart | output | 1 | One-cycle start pulse to the line engine |
| engOp | output | 3 | Operation code for the engine |
| engArg | output | 8 | Argument byte for the engine |
| engDone | input | 1 | Engine finished pulse |
| engFlags | input | 5 | Result flags {dir, second bit, single bit, short, presence} |
| engData | input | 8 | Byte received by the engine |
| lineLevel | input | 1 | Sensed line level, shown live in status bit 3 |
| cfgOut | output | 4 | Active configuration |
| chanOut | output | 3 | Active channel index |

## Verification
The bench builds the block with NUM_CHAN at its default of eight, so every channel write code and read-back code is reachable. This covers the last code, 0x87, where the write and read-back values coincide. The out-of-range channel path, which only exists for smaller channel counts, is therefore reached only through non-code parameters. Busy-window behaviour is exercised by holding `engDone` back, so that dropped commands and a device reset land inside a running operation.

// File: rtl/owb_pkg.sv
package owb_pkg;
  localparam logic [7:0] CMD_DEVRST = 8'hF0;
  localparam logic [7:0] CMD_SETPTR = 8'hE1;
  localparam logic [7:0] CMD_CHAN   = 8'hC3;
  localparam logic [7:0] CMD_CFG    = 8'hD2;
  localparam logic [7:0] CMD_LRST   = 8'hB4;
  localparam logic [7:0] CMD_BIT    = 8'h87;
  localparam logic [7:0] CMD_WBYTE  = 8'hA5;
  localparam logic [7:0] CMD_RBYTE  = 8'h96;
  localparam logic [7:0] CMD_TRIP   = 8'h78;

  localparam logic [7:0] PSEL_STAT = 8'hF0;
  localparam logic [7:0] PSEL_DATA = 8'hE1;
  localparam logic [7:0] PSEL_CHAN = 8'hD2;
  localparam logic [7:0] PSEL_CFG  = 8'hC3;

  typedef enum logic [2:0] {
    OP_NONE = 3'd0, OP_LRST = 3'd1, OP_BIT = 3'd2,
    OP_WBYTE = 3'd3, OP_RBYTE = 3'd4, OP_TRIP = 3'd5
  } eng_op_e;

  typedef enum logic [1:0] {PTR_STAT, PTR_DATA, PTR_CHAN, PTR_CFG} rd_ptr_e;

  typedef struct packed {
    logic       devRst;
    logic       cfgWr;
    logic [3:0] cfgVal;
    logic       chanWr;
    logic [2:0] chanIdx;
    logic       launch;
    eng_op_e    op;
  } ctrl_strb_t;

  function automatic logic [7:0] chanWrCode(input logic [2:0] idx);
    return 8'hF0 - ({5'd0, idx} * 8'h0F);
  endfunction

  function automatic logic [7:0] chanRdCode(input logic [2:0] idx);
    return 8'hB8 - ({5'd0, idx} * 8'h07);
  endfunction
endpackage

// File: rtl/owb_ctrl.sv
module owb_ctrl
  import owb_pkg::*;
#(
  parameter int NUM_CHAN = 8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       hostWr,
  input  logic       hostFirst,
  input  logic [7:0] hostData,
  input  logic       busy,
  output ctrl_strb_t strb,
  output rd_ptr_e    readPtr,
  output logic       engStart,
  output eng_op_e    engOp,
  output logic [7:0] engArg
);
  logic       pendValid;
  logic [7:0] pendCmd;
  rd_ptr_e    nxtPtr;
  logic [7:0] nxtArg;
  logic       needsParam;

  always_comb begin
    needsParam = (hostData == CMD_SETPTR) || (hostData == CMD_CHAN) ||
                 (hostData == CMD_CFG) || (hostData == CMD_BIT) ||
                 (hostData == CMD_WBYTE) || (hostData == CMD_TRIP);
  end

  always_comb begin
    strb   = '0;
    nxtPtr = readPtr;
    nxtArg = 8'h00;
    if (hostWr && hostFirst) begin
      case (hostData)
        CMD_DEVRST: begin strb.devRst = 1'b1; nxtPtr = PTR_STAT; end
        CMD_LRST, CMD_RBYTE: if (!busy) begin
          strb.launch = 1'b1;
          strb.op     = (hostData == CMD_LRST) ? OP_LRST : OP_RBYTE;
          nxtPtr      = PTR_STAT;
        end
        default: ;
      endcase
    end else if (hostWr && pendValid) begin
      case (pendCmd)
        CMD_SETPTR: begin
          case (hostData)
            PSEL_STAT: nxtPtr = PTR_STAT;
            PSEL_DATA: nxtPtr = PTR_DATA;
            PSEL_CHAN: nxtPtr = PTR_CHAN;
            PSEL_CFG:  nxtPtr = PTR_CFG;
            default: ;
          endcase
        end
        CMD_CFG: if (hostData[7:4] == ~hostData[3:0]) begin
          strb.cfgWr  = 1'b1;
          strb.cfgVal = hostData[3:0];
          nxtPtr      = PTR_CFG;
        end
        CMD_CHAN: begin
          for (int i = 0; i < NUM_CHAN; i++) begin
            if (hostData == chanWrCode(3'(i))) begin
              strb.chanWr  = 1'b1;
              strb.chanIdx = 3'(i);
              nxtPtr       = PTR_CHAN;
            end
          end
        end
        CMD_BIT, CMD_WBYTE, CMD_TRIP: if (!busy) begin
          strb.launch = 1'b1;
          nxtPtr      = PTR_STAT;
          if (pendCmd == CMD_WBYTE) begin
            strb.op = OP_WBYTE;
            nxtArg  = hostData;
          end else begin
            strb.op = (pendCmd == CMD_BIT) ? OP_BIT : OP_TRIP;
            nxtArg  = {8{hostData[7]}};
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pendValid <= 1'b0;
      pendCmd   <= 8'h00;
      readPtr   <= PTR_STAT;
      engStart  <= 1'b0;
      engOp     <= OP_NONE;
      engArg    <= 8'h00;
    end else begin
      readPtr  <= nxtPtr;
      engStart <= strb.launch;
      engOp    <= strb.launch ? strb.op : OP_NONE;
      engArg   <= nxtArg;
      if (hostWr) begin
        pendValid <= hostFirst && needsParam;
        if (hostFirst) pendCmd <= hostData;
      end
    end
  end

  AST_SINGLE_START: assert property (@(posedge clk) disable iff (!rst_n)
    engStart |=> !engStart); // R8
  AST_NO_LAUNCH_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    engStart |-> !$past(busy)); // R9
  AST_PTR_AFTER_CFG: assert property (@(posedge clk) disable iff (!rst_n)
    $past(strb.cfgWr) |-> readPtr == PTR_CFG); // R3
endmodule

// File: rtl/owb_regs.sv
module owb_regs
  import owb_pkg::*;
#(
  parameter int NUM_CHAN = 8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  ctrl_strb_t strb,
  input  rd_ptr_e    readPtr,
  input  logic       engDone,
  input  logic [4:0] engFlags,
  input  logic [7:0] engData,
  input  logic       lineLevel,
  output logic       busy,
  output logic [7:0] rdData,
  output logic [3:0] cfgOut,
  output logic [2:0] chanOut
);
  logic [3:0] cfgReg;
  logic [2:0] chanReg;
  logic       rstFlag;
  logic [4:0] resFlags;
  logic [7:0] dataReg;
  eng_op_e    lastOp;
  logic [7:0] statusByte;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfgReg <= '0; chanReg <= '0; rstFlag <= 1'b1; busy <= 1'b0;
      resFlags <= '0; dataReg <= '0; lastOp <= OP_NONE;
    end else if (strb.devRst) begin
      cfgReg <= '0; chanReg <= '0; rstFlag <= 1'b1; busy <= 1'b0;
      resFlags <= '0; dataReg <= '0; lastOp <= OP_NONE;
    end else begin
      if (strb.cfgWr) begin
        cfgReg  <= strb.cfgVal;
        rstFlag <= 1'b0;
      end
      if (strb.chanWr) chanReg <= strb.chanIdx;
      if (strb.launch) begin
        busy   <= 1'b1;
        lastOp <= strb.op;
      end else if (engDone && busy) begin
        busy     <= 1'b0;
        resFlags <= engFlags;
        if (lastOp == OP_RBYTE) dataReg <= engData;
      end
    end
  end

  assign statusByte = {resFlags[4:2], rstFlag, lineLevel, resFlags[1:0], busy};
  assign cfgOut  = cfgReg;
  assign chanOut = chanReg;

  always_comb begin
    case (readPtr)
      PTR_STAT: rdData = statusByte;
      PTR_DATA: rdData = dataReg;
      PTR_CHAN: rdData = chanRdCode(chanReg);
      default:  rdData = {4'b0000, cfgReg};
    endcase
  end

  AST_CFG_GUARDED: assert property (@(posedge clk) disable iff (!rst_n)
    (cfgReg != $past(cfgReg)) |-> $past(strb.cfgWr || strb.devRst)); // R5
  AST_RST_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rstFlag) |-> $past(strb.devRst)); // R7
  AST_BUSY_FROM_LAUNCH: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(strb.launch)); // R8
  AST_CHAN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    32'(chanReg) < NUM_CHAN); // R6
endmodule

// File: rtl/owb_cmd_bridge.sv
module owb_cmd_bridge
  import owb_pkg::*;
#(
  parameter int NUM_CHAN = 8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       hostWr,
  input  logic       hostFirst,
  input  logic [7:0] hostData,
  output logic [7:0] rdData,
  output logic       engStart,
  output logic [2:0] engOp,
  output logic [7:0] engArg,
  input  logic       engDone,
  input  logic [4:0] engFlags,
  input  logic [7:0] engData,
  input  logic       lineLevel,
  output logic [3:0] cfgOut,
  output logic [2:0] chanOut
);
  ctrl_strb_t strb;
  rd_ptr_e    readPtr;
  eng_op_e    opInt;
  logic       busy;

  owb_ctrl #(.NUM_CHAN(NUM_CHAN)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .hostWr(hostWr), .hostFirst(hostFirst),
    .hostData(hostData), .busy(busy), .strb(strb), .readPtr(readPtr),
    .engStart(engStart), .engOp(opInt), .engArg(engArg)
  );

  owb_regs #(.NUM_CHAN(NUM_CHAN)) u_regs (
    .clk(clk), .rst_n(rst_n), .strb(strb), .readPtr(readPtr),
    .engDone(engDone), .engFlags(engFlags), .engData(engData),
    .lineLevel(lineLevel), .busy(busy), .rdData(rdData),
    .cfgOut(cfgOut), .chanOut(chanOut)
  );

  assign engOp = opInt;
endmodule

// File: tb/tb_owb_cmd_bridge.sv
module tb_owb_cmd_bridge;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0, rst_n = 1'b0;
  logic hostWr = 1'b0, hostFirst = 1'b0;
  logic [7:0] hostData = 8'h00;
  logic [7:0] rdData;
  logic engStart;
  logic [2:0] engOp;
  logic [7:0] engArg;
  logic engDone = 1'b0;
  logic [4:0] engFlags = 5'd0;
  logic [7:0] engData = 8'h00;
  logic lineLevel = 1'b1;
  logic [3:0] cfgOut;
  logic [2:0] chanOut;

  int nChecks = 0, nFails = 0;

  owb_cmd_bridge dut (
    .clk(clk), .rst_n(rst_n), .hostWr(hostWr), .hostFirst(hostFirst),
    .hostData(hostData), .rdData(rdData), .engStart(engStart),
    .engOp(engOp), .engArg(engArg), .engDone(engDone),
    .engFlags(engFlags), .engData(engData), .lineLevel(lineLevel),
    .cfgOut(cfgOut), .chanOut(chanOut)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;

  // {command, parameter, expected read value}
  localparam logic [23:0] VEC [12] = '{
    {8'hE1, 8'hC3, 8'h00},  // R2 R4 point at config
    {8'hD2, 8'h5A, 8'h0A},  // R5 valid config
    {8'hD2, 8'h3C, 8'h0C},  // R5 valid config
    {8'hD2, 8'h4C, 8'h0C},  // R5 bad complement ignored
    {8'hC3, 8'hE1, 8'hB1},  // R6 channel 1
    {8'hC3, 8'h87, 8'h87},  // R6 channel 7
    {8'hC3, 8'h55, 8'h87},  // R6 bad code ignored
    {8'hE1, 8'hF0, 8'h08},  // R7 reset flag cleared
    {8'hE1, 8'h12, 8'h08},  // R2 bad pointer ignored
    {8'hE1, 8'hD2, 8'h87},  // R2 channel pointer
    {8'hC3, 8'hF0, 8'hB8},  // R6 channel 0
    {8'hD2, 8'hF0, 8'h00}   // R3 config pointer, value 0
  };

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual 0x%02h expected 0x%02h", tag, act, exp);
    end
  endtask

  task automatic sendByte(input logic first, input logic [7:0] b);
    @(negedge clk);
    hostWr = 1'b1; hostFirst = first; hostData = b;
    @(negedge clk);
    hostWr = 1'b0; hostFirst = 1'b0;
  endtask

  task automatic sendCmd(input logic [7:0] c, input logic [7:0] p);
    sendByte(1'b1, c);
    sendByte(1'b0, p);
  endtask

  task automatic finishOp(input logic [4:0] f, input logic [7:0] d);
    @(negedge clk);
    engDone = 1'b1; engFlags = f; engData = d;
    @(negedge clk);
    engDone = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    nFails++;
    $display("FAIL watchdog: actual running expected finished");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 reset status", rdData, 8'h18);
    check("R1 reset cfgOut", {4'h0, cfgOut}, 8'h00);
    check("R1 reset chanOut", {5'h0, chanOut}, 8'h00);
    check("R1 reset engStart", {7'h0, engStart}, 8'h00);

    for (int i = 0; i < 12; i++) begin
      sendCmd(VEC[i][23:16], VEC[i][15:8]);
      check($sformatf("table entry %0d", i), rdData, VEC[i][7:0]);
    end

    // R8 bus reset launch, pointer left on config by last table entry (R3)
    sendByte(1'b1, 8'hB4);
    check("R8 start pulse", {7'h0, engStart}, 8'h01);
    check("R8 op bus reset", {5'h0, engOp}, 8'h01);
    check("R11 arg bus reset", engArg, 8'h00);
    check("R3 pointer to status, busy set", rdData, 8'h09);
    @(negedge clk);
    check("R8 pulse one cycle", {7'h0, engStart}, 8'h00);

    // R9 write byte while busy is dropped
    sendCmd(8'hA5, 8'h33);
    check("R9 no start when busy", {7'h0, engStart}, 8'h00);
    check("R9 status unchanged", rdData, 8'h09);

    finishOp(5'b00001, 8'h00);
    check("R10 presence flag, busy clear", rdData, 8'h0A);

    sendCmd(8'hA5, 8'h3C);
    check("R11 write byte arg", engArg, 8'h3C);
    check("R8 op write byte", {5'h0, engOp}, 8'h03);
    finishOp(5'b00000, 8'h00);

    sendCmd(8'h87, 8'h80);
    check("R11 single bit arg", engArg, 8'hFF);
    check("R8 op single bit", {5'h0, engOp}, 8'h02);
    finishOp(5'b00100, 8'h00);
    check("R10 single bit flag", rdData, 8'h28);

    sendCmd(8'h78, 8'h7F);
    check("R11 triplet arg", engArg, 8'h00);
    check("R8 op triplet", {5'h0, engOp}, 8'h05);
    finishOp(5'b11000, 8'h00);
    check("R10 triplet flags", rdData, 8'hC8);

    sendByte(1'b1, 8'h96);
    check("R8 op read byte", {5'h0, engOp}, 8'h04);
    finishOp(5'b00000, 8'hA7);
    sendCmd(8'hE1, 8'hE1);
    check("R10 data after read byte", rdData, 8'hA7);

    sendCmd(8'hA5, 8'h11);
    finishOp(5'b00000, 8'h55);
    sendCmd(8'hE1, 8'hE1);
    check("R10 data kept after write byte", rdData, 8'hA7);

    // R12 unknown command and orphan parameter
    sendByte(1'b1, 8'h11);
    check("R12 unknown command", rdData, 8'hA7);
    sendByte(1'b0, 8'hF0);
    check("R12 orphan parameter", rdData, 8'hA7);

    // R1 device reset during busy restores reset state
    sendCmd(8'hD2, 8'h69);
    sendCmd(8'hC3, 8'hD2);
    check("R6 channel out", {5'h0, chanOut}, 8'h02);
    check("R4 cfg out", {4'h0, cfgOut}, 8'h09);
    sendByte(1'b1, 8'hB4);
    sendByte(1'b1, 8'hF0);
    check("R1 device reset status", rdData, 8'h18);
    check("R1 device reset cfgOut", {4'h0, cfgOut}, 8'h00);
    check("R1 device reset chanOut", {5'h0, chanOut}, 8'h00);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end
endmodule